// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a two-port synchronous RAM in which each side has its own active-low chip enable, output enable and read/write strobe, an address and a data word. On top of plain storage it provides a pair of mailboxes at the two highest addresses. Side A's interrupt output goes low when side B writes the word just below the top address. Side B's interrupt goes low when side A writes the top address. Each side acknowledges its interrupt by looking at its own incoming mailbox. The mailbox words remain ordinary memory cells, so the message contents are left to the two processors.

Both sides are sampled on the rising edge of one clock. Write data is stored on that edge. Read data appears on the read-data output after the edge of the read cycle and is held until the next read. The interrupt outputs are registered and change on the edge that follows the causing access. A parameter sets the address width (for example 12 or 13 bits); the mailboxes always sit at the top two addresses. A second parameter removes the mailbox function, and the block is then a plain dual-port RAM.

Top module: `mbox_dpram`

## Requirements
- R1: A write happens on a rising edge when a side has ce_n=0 and we_n=0. A read happens when a side has ce_n=0 and we_n=1; the word is shown on that side's rdata after that edge and is held until that side's next read. A read in the same cycle as a write by the other side to the same address returns the old word.
- R2: When side B writes address 2^ADDR_W-2, pa_int_n is low after that edge.
- R3: When side A has ce_n=0 and oe_n=0 at address 2^ADDR_W-2, pa_int_n is high after that edge, whatever the level of we_n. With oe_n=1 the flag is not cleared.
- R4: When side A writes address 2^ADDR_W-1, pb_int_n is low after that edge.
- R5: When side B reads address 2^ADDR_W-1 with ce_n=0, oe_n=0 and we_n=1, pb_int_n is high after that edge. A read with oe_n=1 does not clear the flag.
- R6: Both mailbox addresses store and return 16-bit words like any other address.
- R7: If a set and a clear of the same flag fall in one cycle, the flag ends up set (interrupt low).
- R8: A synchronous active-high rst drives both pa_int_n and pb_int_n high.
- R9: With INT_EN=0, pa_int_n and pb_int_n stay high at all times, and the top two addresses act purely as memory.
- R10: With ce_n=1 a side neither writes nor changes any flag. A side that writes its own incoming mailbox does not set the other side's interrupt.
- R11: When both sides write the same address in one cycle, side B's word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pa_ce_n | input | 1 | Side A chip enable, active low |
| pa_oe_n | input | 1 | Side A output enable, active low |
| pa_we_n | input | 1 | Side A write strobe, low = write, high = read |
| pa_addr | input | ADDR_W | Side A address |
| pa_wdata | input | DATA_W | Side A write data |
| pa_rdata | output | DATA_W | Side A read data, registered |
| pa_int_n | output | 1 | Side A interrupt, active low |
| pb_ce_n | input | 1 | Side B chip enable, active low |
| pb_oe_n | input | 1 | Side B output enable, active low |
| pb_we_n | input | 1 | Side B write strobe, low = write, high = read |
| pb_addr | input | ADDR_W | Side B address |
| pb_wdata | input | DATA_W | Side B write data |
| pb_rdata | output | DATA_W | Side B read data, registered |
| pb_int_n | output | 1 | Side B interrupt, active low |

## Verification
A flag's set by the far side and its clear by the owning side can land on the same edge. The bench drives one cycle in which side B writes the lower mailbox while side A reads it with output enable low. In another cycle, side A writes the top mailbox while side B reads it. In both cases the interrupt must end up low, and the read must return the word stored before that edge. The next vectors then check that a plain clear by the owning side still releases the interrupt.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Decoded per-side control, active high
    typedef struct packed {
        logic wr;    // store this cycle
        logic rd;    // fetch this cycle
        logic look;  // selected with output enable asserted
    } port_ctl_t;

    function automatic port_ctl_t port_decode(input logic ce_n,
                                              input logic oe_n,
                                              input logic we_n);
        port_ctl_t c;
        c.wr   = !ce_n && !we_n;
        c.rd   = !ce_n &&  we_n;
        c.look = !ce_n && !oe_n;
        return c;
    endfunction

    // Flag update rule: a set always beats a clear
    function automatic logic flag_next(input logic cur,
                                       input logic set,
                                       input logic clr);
        if (set)
            return 1'b1;
        else if (clr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int IN_BOX       = 254,
    parameter int OUT_BOX      = 255,
    parameter bit CLR_NEEDS_RD = 1'b0
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output port_ctl_t         ctl,
    output logic              post_out,
    output logic              ack_in
);
    localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(IN_BOX);
    localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OUT_BOX);

    port_ctl_t c;
    logic      at_in;
    logic      at_out;

    always_comb begin
        c      = port_decode(ce_n, oe_n, we_n);
        at_in  = (addr == IN_A);
        at_out = (addr == OUT_A);
    end

    assign ctl      = c;
    assign post_out = c.wr && at_out;

    generate
        if (CLR_NEEDS_RD) begin : g_rd_ack
            assign ack_in = c.look && c.rd && at_in;
        end else begin : g_any_ack
            assign ack_in = c.look && at_in;
        end
    endgenerate

endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;

    // Side B is written last so it wins a same-address collision
    always_ff @(posedge clk) begin
        if (a_wr)
            mem[a_addr] <= a_wdata;
        if (b_wr)
            mem[b_addr] <= b_wdata;
    end

    always_ff @(posedge clk) begin
        if (a_rd)
            a_q <= mem[a_addr];
        if (b_rd)
            b_q <= mem[b_addr];
    end

    assign a_rdata = a_q;
    assign b_rdata = b_q;

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    generate
        if (ENABLE) begin : g_live
            logic pend;
            always_ff @(posedge clk) begin
                if (rst)
                    pend <= 1'b0;
                else
                    pend <= flag_next(pend, set, clr);
            end
            assign irq_n = !pend;
        end else begin : g_off
            logic unused_in;
            assign unused_in = set ^ clr ^ clk ^ rst;
            assign irq_n     = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter bit INT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pa_ce_n,
    input  logic              pa_oe_n,
    input  logic              pa_we_n,
    input  logic [ADDR_W-1:0] pa_addr,
    input  logic [DATA_W-1:0] pa_wdata,
    output logic [DATA_W-1:0] pa_rdata,
    output logic              pa_int_n,
    input  logic              pb_ce_n,
    input  logic              pb_oe_n,
    input  logic              pb_we_n,
    input  logic [ADDR_W-1:0] pb_addr,
    input  logic [DATA_W-1:0] pb_wdata,
    output logic [DATA_W-1:0] pb_rdata,
    output logic              pb_int_n
);
    localparam int TOP_ADDR = (1 << ADDR_W) - 1;
    localparam int BOX_TO_A = TOP_ADDR - 1;  // B posts here, A acknowledges
    localparam int BOX_TO_B = TOP_ADDR;      // A posts here, B acknowledges

    port_ctl_t a_ctl;
    port_ctl_t b_ctl;
    logic      a_post;
    logic      a_ack;
    logic      b_post;
    logic      b_ack;

    mbox_port_dec #(
        .ADDR_W      (ADDR_W),
        .IN_BOX      (BOX_TO_A),
        .OUT_BOX     (BOX_TO_B),
        .CLR_NEEDS_RD(1'b0)
    ) u_dec_a (
        .ce_n    (pa_ce_n),
        .oe_n    (pa_oe_n),
        .we_n    (pa_we_n),
        .addr    (pa_addr),
        .ctl     (a_ctl),
        .post_out(a_post),
        .ack_in  (a_ack)
    );

    mbox_port_dec #(
        .ADDR_W      (ADDR_W),
        .IN_BOX      (BOX_TO_B),
        .OUT_BOX     (BOX_TO_A),
        .CLR_NEEDS_RD(1'b1)
    ) u_dec_b (
        .ce_n    (pb_ce_n),
        .oe_n    (pb_oe_n),
        .we_n    (pb_we_n),
        .addr    (pb_addr),
        .ctl     (b_ctl),
        .post_out(b_post),
        .ack_in  (b_ack)
    );

    mbox_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk    (clk),
        .a_wr   (a_ctl.wr),
        .a_rd   (a_ctl.rd),
        .a_addr (pa_addr),
        .a_wdata(pa_wdata),
        .a_rdata(pa_rdata),
        .b_wr   (b_ctl.wr),
        .b_rd   (b_ctl.rd),
        .b_addr (pb_addr),
        .b_wdata(pb_wdata),
        .b_rdata(pb_rdata)
    );

    // Flag for side A: set by B's post, cleared by A's look
    mbox_flag #(.ENABLE(INT_EN)) u_flag_a (
        .clk  (clk),
        .rst  (rst),
        .set  (b_post),
        .clr  (a_ack),
        .irq_n(pa_int_n)
    );

    // Flag for side B: set by A's post, cleared by B's read
    mbox_flag #(.ENABLE(INT_EN)) u_flag_b (
        .clk  (clk),
        .rst  (rst),
        .set  (a_post),
        .clr  (b_ack),
        .irq_n(pb_int_n)
    );

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter bit INT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              pa_ce_n,
    input logic              pa_oe_n,
    input logic              pa_we_n,
    input logic [ADDR_W-1:0] pa_addr,
    input logic [DATA_W-1:0] pa_wdata,
    input logic [DATA_W-1:0] pa_rdata,
    input logic              pa_int_n,
    input logic              pb_ce_n,
    input logic              pb_oe_n,
    input logic              pb_we_n,
    input logic [ADDR_W-1:0] pb_addr,
    input logic [DATA_W-1:0] pb_wdata,
    input logic [DATA_W-1:0] pb_rdata,
    input logic              pb_int_n
);
    localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

    logic b_posts;
    logic a_posts;
    logic a_looks;
    logic b_reads;
    assign b_posts = !pb_ce_n && !pb_we_n && (pb_addr == LO);
    assign a_posts = !pa_ce_n && !pa_we_n && (pa_addr == HI);
    assign a_looks = !pa_ce_n && !pa_oe_n && (pa_addr == LO);
    assign b_reads = !pb_ce_n && !pb_oe_n && pb_we_n && (pb_addr == HI);

    logic unused_bus;
    assign unused_bus = ^{pa_wdata, pb_wdata, pa_rdata, pb_rdata};

    assert_reset_high_R8: assert property (@(posedge clk)
        rst |=> (pa_int_n && pb_int_n));

    generate
        if (INT_EN) begin : g_on
            // R2 and R7: a post always leaves the flag set
            assert_a_set_R2: assert property (@(posedge clk) disable iff (rst)
                b_posts |=> !pa_int_n);
            assert_a_clear_R3: assert property (@(posedge clk) disable iff (rst)
                (a_looks && !b_posts) |=> pa_int_n);
            assert_b_set_R4: assert property (@(posedge clk) disable iff (rst)
                a_posts |=> !pb_int_n);
            assert_b_clear_R5: assert property (@(posedge clk) disable iff (rst)
                (b_reads && !a_posts) |=> pb_int_n);
            assert_a_only_by_post_R10: assert property (@(posedge clk) disable iff (rst)
                $fell(pa_int_n) |-> $past(b_posts));
            assert_b_only_by_post_R10: assert property (@(posedge clk) disable iff (rst)
                $fell(pb_int_n) |-> $past(a_posts));
            assert_a_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (!pa_int_n && !a_looks) |=> !pa_int_n);
        end else begin : g_off
            assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
                (b_posts || a_posts) |=> (pa_int_n && pb_int_n));
        end
    endgenerate

endmodule

bind mbox_dpram mbox_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .INT_EN(INT_EN)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pa_ce_n (pa_ce_n),
    .pa_oe_n (pa_oe_n),
    .pa_we_n (pa_we_n),
    .pa_addr (pa_addr),
    .pa_wdata(pa_wdata),
    .pa_rdata(pa_rdata),
    .pa_int_n(pa_int_n),
    .pb_ce_n (pb_ce_n),
    .pb_oe_n (pb_oe_n),
    .pb_we_n (pb_we_n),
    .pb_addr (pb_addr),
    .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata),
    .pb_int_n(pb_int_n)
);

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
    localparam int AW = 8;
    localparam int DW = 16;

    // ctl fields are {ce_n, oe_n, we_n}
    localparam logic [2:0] IDL = 3'b111;
    localparam logic [2:0] WR  = 3'b010;  // write, oe high
    localparam logic [2:0] WRO = 3'b000;  // write, oe low
    localparam logic [2:0] RDO = 3'b001;  // read, oe low
    localparam logic [2:0] RD  = 3'b011;  // read, oe high
    localparam logic [2:0] NCE = 3'b110;  // deselected, we low

    typedef struct packed {
        logic [7:0]    req;
        logic [2:0]    actl;
        logic [AW-1:0] aadr;
        logic [DW-1:0] awd;
        logic [2:0]    bctl;
        logic [AW-1:0] badr;
        logic [DW-1:0] bwd;
        logic          eai;
        logic          ebi;
        logic          cka;
        logic [DW-1:0] ear;
        logic          ckb;
        logic [DW-1:0] ebr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{8'd1,  WR,  8'h10, 16'h1234, IDL, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd1,  IDL, 8'h00, 16'h0000, RDO, 8'h10, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h1234},
        '{8'd2,  IDL, 8'h00, 16'h0000, WR,  8'hFE, 16'hBEEF, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd3,  RDO, 8'hFE, 16'h0000, IDL, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hBEEF, 1'b0, 16'h0000},
        '{8'd2,  IDL, 8'h00, 16'h0000, WR,  8'hFE, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd3,  WRO, 8'hFE, 16'h5555, IDL, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd6,  IDL, 8'h00, 16'h0000, WR,  8'hFE, 16'h0002, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd3,  RD,  8'hFE, 16'h0000, IDL, 8'h00, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0002, 1'b0, 16'h0000},
        '{8'd3,  RDO, 8'hFE, 16'h0000, IDL, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h0002, 1'b0, 16'h0000},
        '{8'd4,  WR,  8'hFF, 16'hCAFE, IDL, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd5,  IDL, 8'h00, 16'h0000, RD,  8'hFF, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hCAFE},
        '{8'd5,  IDL, 8'h00, 16'h0000, RDO, 8'hFF, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hCAFE},
        '{8'd7,  WR,  8'hFF, 16'hAAAA, RDO, 8'hFF, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hCAFE},
        '{8'd7,  RDO, 8'hFE, 16'h0000, WR,  8'hFE, 16'h7777, 1'b0, 1'b0, 1'b1, 16'h0002, 1'b0, 16'h0000},
        '{8'd6,  RDO, 8'hFE, 16'h0000, RDO, 8'hFF, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h7777, 1'b1, 16'hAAAA},
        '{8'd10, WR,  8'hFE, 16'h3333, WR,  8'hFF, 16'h4444, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd10, NCE, 8'hFF, 16'h9999, NCE, 8'hFE, 16'h8888, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
        '{8'd11, WR,  8'h20, 16'h1111, WR,  8'h20, 16'h2222, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pa_ce_n = 1'b1, pa_oe_n = 1'b1, pa_we_n = 1'b1;
    logic          pb_ce_n = 1'b1, pb_oe_n = 1'b1, pb_we_n = 1'b1;
    logic [AW-1:0] pa_addr = '0, pb_addr = '0;
    logic [DW-1:0] pa_wdata = '0, pb_wdata = '0;
    logic [DW-1:0] pa_rdata, pb_rdata, qa_rdata, qb_rdata;
    logic          pa_int_n, pb_int_n, qa_int_n, qb_int_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .INT_EN(1'b1)) i_mbox_dpram (
        .clk(clk), .rst(rst),
        .pa_ce_n(pa_ce_n), .pa_oe_n(pa_oe_n), .pa_we_n(pa_we_n),
        .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_rdata(pa_rdata), .pa_int_n(pa_int_n),
        .pb_ce_n(pb_ce_n), .pb_oe_n(pb_oe_n), .pb_we_n(pb_we_n),
        .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .pb_int_n(pb_int_n)
    );

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .INT_EN(1'b0)) i_mbox_dpram_noint (
        .clk(clk), .rst(rst),
        .pa_ce_n(pa_ce_n), .pa_oe_n(pa_oe_n), .pa_we_n(pa_we_n),
        .pa_addr(pa_addr), .pa_wdata(pa_wdata), .pa_rdata(qa_rdata), .pa_int_n(qa_int_n),
        .pb_ce_n(pb_ce_n), .pb_oe_n(pb_oe_n), .pb_we_n(pb_we_n),
        .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_rdata(qb_rdata), .pb_int_n(qb_int_n)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] ac, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                         input logic [2:0] bc, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
        {pa_ce_n, pa_oe_n, pa_we_n} = ac;
        pa_addr = aa; pa_wdata = ad;
        {pb_ce_n, pb_oe_n, pb_we_n} = bc;
        pb_addr = ba; pb_wdata = bd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check("R8 pa_int_n after reset", DW'(pa_int_n), 16'h1);
        check("R8 pb_int_n after reset", DW'(pb_int_n), 16'h1);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].actl, TBL[i].aadr, TBL[i].awd, TBL[i].bctl, TBL[i].badr, TBL[i].bwd);
            @(negedge clk);
            check($sformatf("R%0d vec%0d pa_int_n", TBL[i].req, i), DW'(pa_int_n), DW'(TBL[i].eai));
            check($sformatf("R%0d vec%0d pb_int_n", TBL[i].req, i), DW'(pb_int_n), DW'(TBL[i].ebi));
            if (TBL[i].cka) begin
                check($sformatf("R%0d vec%0d pa_rdata", TBL[i].req, i), pa_rdata, TBL[i].ear);
                check($sformatf("R9 vec%0d noint pa_rdata", i), qa_rdata, TBL[i].ear);
            end
            if (TBL[i].ckb) begin
                check($sformatf("R%0d vec%0d pb_rdata", TBL[i].req, i), pb_rdata, TBL[i].ebr);
                check($sformatf("R9 vec%0d noint pb_rdata", i), qb_rdata, TBL[i].ebr);
            end
            // R9: disabled variant never interrupts
            check($sformatf("R9 vec%0d noint ints", i), DW'({qa_int_n, qb_int_n}), 16'h3);
        end

        // R11: collision at 0x20 kept side B's word
        drive(RDO, 8'h20, 16'h0, IDL, 8'h0, 16'h0);
        @(negedge clk);
        check("R11 collision word", pa_rdata, 16'h2222);

        // R6 and R1: mailbox words readable through both sides
        drive(IDL, 8'h0, 16'h0, RD, 8'hFE, 16'h0);
        @(negedge clk);
        check("R6 mailbox FE via B", pb_rdata, 16'h3333);
        drive(RD, 8'hFF, 16'h0, IDL, 8'h0, 16'h0);
        @(negedge clk);
        check("R6 mailbox FF via A", pa_rdata, 16'h4444);
        drive(IDL, 8'h0, 16'h0, IDL, 8'h0, 16'h0);
        @(negedge clk);
        check("R1 rdata held while idle", pa_rdata, 16'h4444);

        // R8: set both flags, then reset clears them
        drive(WR, 8'hFF, 16'h0101, WR, 8'hFE, 16'h0202);
        @(negedge clk);
        check("R2 R4 both set", DW'({pa_int_n, pb_int_n}), 16'h0);
        drive(IDL, 8'h0, 16'h0, IDL, 8'h0, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset releases both", DW'({pa_int_n, pb_int_n}), 16'h3);
        @(negedge clk);
        check("R8 stays released", DW'({pa_int_n, pb_int_n}), 16'h3);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule